// File: doc/BRIEF.md
# Compare-Match Software Timer Unit

This peripheral keeps a 16-bit free-running timer and a small table of software timer slots. Software writes a target time into a slot, and that write arms the slot. Every armed slot is compared against the timer on each count. When the timer reaches a slot's target, the slot raises its status flag and disarms itself. When the timer wraps from its maximum value to zero, an overflow flag is raised.

All flags live in one status register that clears on read. Two mask bits turn the flags into interrupt requests. One mask bit gates overflow and the other gates the OR of the software timer flags.

Access goes through a single-cycle register port. There are no data streams, so the port has no valid/ready handshake. A write takes effect at the clock edge where `reg_sel` and `reg_we` are both high. Read data is combinational while `reg_sel` is high and `reg_we` is low.

Address map:

| Address | Register |
|---|---|
| 0 | Timer |
| 1 | Status |
| 2 | Mask |
| 4 + i | Slot i target |

All other addresses read as zero.

Top module: `swtimer_unit`

## Requirements
- R1: While reset is held, the timer, the status register and the mask register all read zero, and both interrupt outputs are low.
- R2: The timer (address 0) advances by one every PRESCALE clocks. It wraps from 0xFFFF to 0x0000 and never stops.
- R3: A write to the timer address is ignored, and the timer keeps counting from its own value.
- R4: A write to address 4+i stores the target for slot i and arms the slot. Status bit i sets on the clock edge where the timer takes that target value. The stored target reads back at the same address.
- R5: All armed slots are compared in parallel, so slots that share a target set their status bits in the same count.
- R6: A slot that has fired is disarmed. It does not fire again when the timer next passes its target, unless it is rewritten.
- R7: The timer wrap to 0x0000 sets status bit 4, the overflow flag.
- R8: A read of the status register (address 1) returns the pending flags (bits 3:0 for slots, bit 4 for overflow) and clears them.
- R9: A flag that sets in the same cycle as a status read is not lost. It is returned by the next status read.
- R10: The mask register (address 2) is read/write. `irq_ovf` is the overflow flag ANDed with mask bit 0. `irq_swt` is the OR of the slot flags ANDed with mask bit 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_sel | input | 1 | Register access strobe |
| reg_we | input | 1 | Write when high, read when low |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_swt | output | 1 | Software timer interrupt request |

## Verification
A wrong prescaler or timer state shows up right away as a timer value that drifts from the count expected over a known number of clocks.

A stuck or missing arm bit has two possible symptoms. A missed flag appears at the first status read after the target count. A second firing appears only when the timer comes round to the target again, so the bench runs the timer through a full wrap to expose it.

Flag corruption shows on the interrupt pins in the cycle after the bad edge. A status read that coincides with a flag setting is exercised by back-to-back reads, where the flag must be seen exactly once.

// File: rtl/swt_pkg.sv
package swt_pkg;
  localparam int ADDR_TIMER  = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_MASK   = 2;
  localparam int SLOT_BASE   = 4;
  localparam int MASK_W      = 8;
  localparam int MASK_OVF    = 0;
  localparam int MASK_SWT    = 5;
endpackage

// File: rtl/swt_timebase.sv
module swt_timebase #(
  parameter int TIMER_W  = 16,
  parameter int PRESCALE = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               tick,
  output logic               wrap,
  output logic [TIMER_W-1:0] timer_q
);
  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  generate
    if (PRESCALE > 1) begin : g_div
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    pre_q <= '0;
        else if (tick) pre_q <= '0;
        else           pre_q <= pre_q + 1'b1;
      end
      assign tick = (pre_q == PRE_W'(PRESCALE - 1));
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

  assign wrap = tick && (timer_q == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    timer_q <= '0;
    else if (tick) timer_q <= timer_q + 1'b1;
  end
endmodule

// File: rtl/swt_match_table.sv
module swt_match_table #(
  parameter int TIMER_W   = 16,
  parameter int NUM_SLOTS = 4
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_SLOTS-1:0]                slot_we,
  input  logic [TIMER_W-1:0]                  wdata,
  input  logic                                tick,
  input  logic [TIMER_W-1:0]                  timer_q,
  output logic [NUM_SLOTS-1:0]                match,
  output logic [NUM_SLOTS-1:0]                armed,
  output logic [NUM_SLOTS-1:0][TIMER_W-1:0]   targets
);
  logic [TIMER_W-1:0] upcoming;
  assign upcoming = timer_q + 1'b1;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    // compare against the value the timer takes at this edge
    assign match[i] = armed[i] && tick && (targets[i] == upcoming);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        targets[i] <= '0;
        armed[i]   <= 1'b0;
      end else if (slot_we[i]) begin
        targets[i] <= wdata;
        armed[i]   <= 1'b1;
      end else if (match[i]) begin
        armed[i]   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/swt_flags.sv
module swt_flags #(
  parameter int NUM_FLAGS = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] set_vec,
  input  logic                 rd_clr,
  output logic [NUM_FLAGS-1:0] flags_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (rd_clr ? '0 : flags_q) | set_vec;
  end
endmodule

// File: rtl/swtimer_unit.sv
module swtimer_unit #(
  parameter int TIMER_W   = 16,
  parameter int NUM_SLOTS = 4,
  parameter int PRESCALE  = 4,
  parameter int ADDR_W    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_sel,
  input  logic               reg_we,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [TIMER_W-1:0] reg_wdata,
  output logic [TIMER_W-1:0] reg_rdata,
  output logic               irq_ovf,
  output logic               irq_swt
);
  import swt_pkg::*;
  localparam int NUM_FLAGS = NUM_SLOTS + 1;

  logic                              tick, wrap;
  logic [TIMER_W-1:0]                timer_q;
  logic [NUM_SLOTS-1:0]              slot_we, match, armed;
  logic [NUM_SLOTS-1:0][TIMER_W-1:0] targets;
  logic [NUM_FLAGS-1:0]              flags_q;
  logic [MASK_W-1:0]                 mask_q;
  logic                              rd_status, wr_mask;

  assign rd_status = reg_sel && !reg_we && (reg_addr == ADDR_W'(ADDR_STATUS));
  assign wr_mask   = reg_sel &&  reg_we && (reg_addr == ADDR_W'(ADDR_MASK));

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_we
    assign slot_we[i] = reg_sel && reg_we && (reg_addr == ADDR_W'(SLOT_BASE + i));
  end

  swt_timebase #(.TIMER_W(TIMER_W), .PRESCALE(PRESCALE)) u_timebase (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wrap(wrap), .timer_q(timer_q)
  );

  swt_match_table #(.TIMER_W(TIMER_W), .NUM_SLOTS(NUM_SLOTS)) u_table (
    .clk(clk), .rst_n(rst_n), .slot_we(slot_we), .wdata(reg_wdata),
    .tick(tick), .timer_q(timer_q), .match(match), .armed(armed),
    .targets(targets)
  );

  swt_flags #(.NUM_FLAGS(NUM_FLAGS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec({wrap, match}),
    .rd_clr(rd_status), .flags_q(flags_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata[MASK_W-1:0];
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_sel && !reg_we) begin
      if (reg_addr == ADDR_W'(ADDR_TIMER))  reg_rdata = timer_q;
      if (reg_addr == ADDR_W'(ADDR_STATUS)) reg_rdata[NUM_FLAGS-1:0] = flags_q;
      if (reg_addr == ADDR_W'(ADDR_MASK))   reg_rdata[MASK_W-1:0] = mask_q;
      for (int i = 0; i < NUM_SLOTS; i++)
        if (reg_addr == ADDR_W'(SLOT_BASE + i)) reg_rdata = targets[i];
    end
  end

  assign irq_ovf = flags_q[NUM_SLOTS] && mask_q[MASK_OVF];
  assign irq_swt = (|flags_q[NUM_SLOTS-1:0]) && mask_q[MASK_SWT];
endmodule

// File: rtl/swtimer_unit_chk.sv
module swtimer_unit_chk #(
  parameter int TIMER_W   = 16,
  parameter int NUM_SLOTS = 4,
  parameter int MASK_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic [TIMER_W-1:0]   timer_q,
  input logic [NUM_SLOTS-1:0] match,
  input logic [NUM_SLOTS-1:0] armed,
  input logic [NUM_SLOTS-1:0] slot_we,
  input logic                 rd_status,
  input logic [NUM_SLOTS:0]   flags_q,
  input logic [MASK_W-1:0]    mask_q,
  input logic                 irq_ovf,
  input logic                 irq_swt
);
  // R2: the timer steps by one on a tick and holds otherwise
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> timer_q == TIMER_W'($past(timer_q) + 1'b1));
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(timer_q));
  // R6: a fired slot is no longer armed unless rewritten
  a_r6_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (match != '0 && slot_we == '0) |=> (armed & $past(match)) == '0);
  // R7: wrapping sets the overflow flag
  a_r7_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && timer_q == '1) |=> flags_q[NUM_SLOTS]);
  // R8: a status read with no new event leaves nothing pending
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && !tick) |=> flags_q == '0);
  // R9: events coinciding with a read stay pending
  a_r9_keep: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_status && match != '0) |=> (flags_q[NUM_SLOTS-1:0] & $past(match)) == $past(match));
  // R10: interrupt requests obey their mask bits
  a_r10_swt_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[5] |-> !irq_swt);
  a_r10_ovf_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_q[0] |-> !irq_ovf);
endmodule

bind swtimer_unit swtimer_unit_chk #(.TIMER_W(TIMER_W), .NUM_SLOTS(NUM_SLOTS), .MASK_W(8)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .timer_q(timer_q), .match(match),
  .armed(armed), .slot_we(slot_we), .rd_status(rd_status), .flags_q(flags_q),
  .mask_q(mask_q), .irq_ovf(irq_ovf), .irq_swt(irq_swt)
);

// File: tb/swtimer_unit_bench.sv
module swtimer_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq_ovf, irq_swt;
  int          n_run = 0, n_fail = 0;
  int          max_target = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  swtimer_unit #(.PRESCALE(2)) u_swtimer_unit (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ovf(irq_ovf), .irq_swt(irq_swt)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // each access occupies exactly one clock, starting and ending on a falling edge
  task automatic reg_wr(input logic [2:0] a, input logic [15:0] d);
    reg_sel = 1'b1; reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_sel = 1'b0; reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [15:0] d);
    reg_sel = 1'b1; reg_we = 1'b0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_sel = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    reg_sel = 1'b1; reg_we = 1'b0;
    reg_addr = 3'd0; #1 v = reg_rdata; check(v == 0, "R1 timer", v, 0);
    reg_addr = 3'd1; #1 v = reg_rdata; check(v == 0, "R1 status", v, 0);
    reg_addr = 3'd2; #1 v = reg_rdata; check(v == 0, "R1 mask", v, 0);
    check(!irq_ovf && !irq_swt, "R1 irqs", {irq_ovf, irq_swt}, 0);
    reg_sel = 1'b0;
  endtask

  task automatic t_prescale;
    logic [15:0] a, b;
    reg_rd(3'd0, a);
    repeat (9) @(negedge clk);
    reg_rd(3'd0, b);
    check(16'(b - a) == 5, "R2 prescale step", 16'(b - a), 5);
  endtask

  task automatic t_timer_ro;
    logic [15:0] a, b;
    reg_rd(3'd0, a);
    reg_wr(3'd0, 16'hBEEF);
    reg_rd(3'd0, b);
    check(16'(b - a) == 1, "R3 timer write ignored", b, 16'(a + 1));
  endtask

  task automatic arm(input int slot, input logic [15:0] tgt);
    reg_wr(3'(4 + slot), tgt);
    if (int'(tgt) > max_target) max_target = int'(tgt);
  endtask

  task automatic t_match_single;
    logic [15:0] t, v;
    reg_wr(3'd2, 16'h0020);
    reg_rd(3'd0, t);
    arm(2, 16'(t + 30));
    repeat (20) @(negedge clk);
    check(!irq_swt, "R4 no early irq", irq_swt, 0);
    repeat (60) @(negedge clk);
    check(irq_swt, "R10 irq_swt raised", irq_swt, 1);
    reg_rd(3'd1, v);
    check(v == 16'h0004, "R4 slot2 flag", v, 4);
    check(!irq_swt, "R8 irq drops after read", irq_swt, 0);
    reg_rd(3'd1, v);
    check(v == 0, "R8 status cleared", v, 0);
    reg_rd(3'd6, v);
    check(v == 16'(t + 30), "R4 target readback", v, 16'(t + 30));
  endtask

  task automatic t_parallel;
    logic [15:0] t, v;
    reg_rd(3'd0, t);
    arm(0, 16'(t + 20));
    arm(3, 16'(t + 20));
    repeat (60) @(negedge clk);
    reg_rd(3'd1, v);
    check(v == 16'h0009, "R5 parallel slots", v, 9);
  endtask

  task automatic t_masked;
    logic [15:0] t, v;
    reg_wr(3'd2, 16'h0000);
    reg_rd(3'd2, v);
    check(v == 0, "R10 mask readback", v, 0);
    reg_rd(3'd0, t);
    arm(1, 16'(t + 15));
    repeat (50) @(negedge clk);
    check(!irq_swt, "R10 masked swt irq", irq_swt, 0);
    reg_rd(3'd1, v);
    check(v == 16'h0002, "R4 masked flag still set", v, 2);
    reg_wr(3'd2, 16'h0021);
  endtask

  task automatic t_same_cycle;
    logic [15:0] t, v;
    int seen = 0;
    logic [15:0] acc = '0;
    reg_rd(3'd0, t);
    arm(1, 16'(t + 20));
    for (int k = 0; k < 80; k++) begin
      reg_rd(3'd1, v);
      if (v[1]) seen++;
      acc |= v;
    end
    check(seen == 1, "R9 flag seen exactly once", seen, 1);
    check(acc == 16'h0002, "R9 only slot1 flag", acc, 2);
  endtask

  task automatic t_overflow;
    logic [15:0] t, v;
    reg_rd(3'd0, t);
    repeat ((16'hFFF0 - int'(t)) * 2) @(negedge clk);
    reg_rd(3'd1, v);
    check(v == 0, "R6 nothing pending before wrap", v, 0);
    check(!irq_ovf, "R10 no ovf irq before wrap", irq_ovf, 0);
    repeat (64) @(negedge clk);
    check(irq_ovf, "R10 ovf irq raised", irq_ovf, 1);
    reg_rd(3'd1, v);
    check(v == 16'h0010, "R7 overflow flag", v, 16'h10);
    check(!irq_ovf, "R8 ovf irq cleared", irq_ovf, 0);
    reg_rd(3'd0, t);
    check(t < 16'h0040, "R2 timer wrapped", t, 16'h20);
    repeat ((max_target + 20) * 2) @(negedge clk);
    reg_rd(3'd1, v);
    check(v == 0, "R6 no refire after wrap", v, 0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_prescale();
    t_timer_ro();
    t_match_single();
    t_parallel();
    t_masked();
    t_same_cycle();
    t_overflow();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule